// File: doc/BRIEF.md
# Trigger-Windowed Peak Readout over UART

This block sits behind a pulse-peak finder and in front of a slow serial link. Every peak record (a timestamp plus an amplitude) offered on its record stream goes into a small ring buffer. While no readout runs, the ring keeps the newest records and drops the oldest when it is full. A trigger pulse opens a readout. The current time at the trigger cycle becomes the window start t0, and the window covers t0 through t0 + win_len inclusive. The block walks the stored records from oldest to newest. It discards those whose timestamp falls outside the window and exports the rest.

Each exported record becomes a fixed packet of bytes: the timestamp bytes first, then the amplitude bytes, most significant byte first in both. The bytes pass through a byte-wide FIFO into an asynchronous serial transmitter. A fractional accumulator produces a tick at 16 times the baud rate from the system clock. The readout stays open until the current time has moved past t0 + win_len and every stored record has been examined. This means peaks that arrive late but belong to the window are still sent. A trigger that arrives while a readout is running is ignored and counted.

The record input uses valid/ready. A record transfers on a cycle where both are high. While idle the block never back-pressures. During a readout, ready drops only when the ring holds DEPTH records that have not been examined. The source must then hold its record stable until ready returns. Timestamps and the current time share one time base, which must not wrap during a readout.

Top module: `peak_window_readout`

## Requirements
- R1: While idle, pk_ready is high and every record is stored. When the ring already holds DEPTH records, the oldest one is overwritten, so a later readout sees only the newest DEPTH records, in arrival order.
- R2: A trigger taken while busy is low sets t0 to now_time in that cycle. Exactly the records with t0 <= timestamp <= t0 + win_len are exported; both ends are inclusive and all other records are skipped.
- R3: A readout stays open, with busy high, while now_time <= t0 + win_len. Records that arrive during that time and fall inside the window are exported. Every record examined by a readout is removed from the ring.
- R4: Each exported record is sent as TS_W/8 timestamp bytes followed by AMP_W/8 amplitude bytes, each field most significant byte first. With the defaults this is 5 bytes: ts[23:16], ts[15:8], ts[7:0], amp[15:8], amp[7:0].
- R5: Each byte goes out as one low start bit, 8 data bits with the least significant bit first, and one high stop bit. Each bit lasts 16 ticks, and the line rests high when idle.
- R6: The tick is produced by a fractional accumulator, so the average bit time is CLK_HZ/BAUD clock cycles with no rounding drift. A start bit followed by a 0x00 byte holds the line low for 9 bit times, within one clock.
- R7: busy goes high in the cycle after an accepted trigger. It falls once the window is closed and the last stop bit has finished. A trigger while busy is high is ignored and increments dropped_trig, which saturates at its maximum.
- R8: During a readout, pk_ready falls when DEPTH unexamined records are stored. No offered record is lost, and all in-window records are exported in arrival order.
- R9: After reset, uart_tx is high, busy is low, pk_ready is high and dropped_trig is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pk_valid | input | 1 | Record offered |
| pk_ready | output | 1 | Record accepted when high together with pk_valid |
| pk_time | input | TS_W (24) | Timestamp of the offered record |
| pk_amp | input | AMP_W (16) | Amplitude of the offered record |
| trigger | input | 1 | One-cycle trigger pulse |
| now_time | input | TS_W (24) | Current time in the timestamp base |
| win_len | input | TS_W (24) | Window length T |
| uart_tx | output | 1 | Serial output line |
| busy | output | 1 | Readout in progress |
| dropped_trig | output | DROP_W (8) | Count of ignored triggers, saturating |

## Verification
A corrupted window bound or a wrong start pointer shows up as wrong or missing bytes on uart_tx within the first packet after the trigger. A wrong byte order inside the packet shows up in the same way. A miscounted pending total or an early close shows at the ports as busy falling while now_time is still inside the window. It can also show as a late in-window record that never appears on the line, which is visible within one record time. A faulty tick accumulator stretches or shrinks the bit time, which a low-run measurement over a zero byte catches within one frame. A lost back-pressure condition drops records, so the exported sequence comes up short.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef logic [7:0] byte_t;
  localparam int TICKS_PER_BIT = 16;
  localparam int TICK_W        = $clog2(TICKS_PER_BIT);
  localparam int SHIFT_BITS    = 9;   // 8 data bits plus stop bit
endpackage

// File: rtl/pwr_ring_scan.sv
module pwr_ring_scan #(
  parameter int DEPTH = 16,
  parameter int TS_W  = 24,
  parameter int AMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_valid,
  output logic             rec_ready,
  input  logic [TS_W-1:0]  rec_ts,
  input  logic [AMP_W-1:0] rec_amp,
  input  logic             start,
  input  logic [TS_W-1:0]  now_time,
  input  logic [TS_W-1:0]  win_len,
  output logic             active,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TS_W-1:0]  out_ts,
  output logic [AMP_W-1:0] out_amp
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TS_W-1:0]  ts_mem  [DEPTH];
  logic [AMP_W-1:0] amp_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] pend;
  logic [TS_W-1:0]  t0;
  logic [TS_W:0]    t_end;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic full, wr_fire, overwrite, have, in_win, pop, close_now;

  always_comb begin
    full      = (pend == CNT_W'(DEPTH));
    rec_ready = !active || !full;
    wr_fire   = rec_valid && rec_ready;
    overwrite = wr_fire && full;
    out_ts    = ts_mem[rd_ptr];
    out_amp   = amp_mem[rd_ptr];
    in_win    = (out_ts >= t0) && ({1'b0, out_ts} <= t_end);
    have      = active && (pend != '0);
    out_valid = have && in_win;
    pop       = have && (!in_win || out_ready);
    close_now = active && (pend == '0) && !wr_fire && ({1'b0, now_time} > t_end);
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      ts_mem[wr_ptr]  <= rec_ts;
      amp_mem[wr_ptr] <= rec_amp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      pend   <= '0;
      active <= 1'b0;
      t0     <= '0;
      t_end  <= '0;
    end else begin
      if (wr_fire) wr_ptr <= nxt(wr_ptr);
      if (pop || overwrite) rd_ptr <= nxt(rd_ptr);
      unique case ({wr_fire && !overwrite, pop})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: ;
      endcase
      if (start && !active) begin
        active <= 1'b1;
        t0     <= now_time;
        t_end  <= {1'b0, now_time} + {1'b0, win_len};
      end else if (close_now) begin
        active <= 1'b0;
      end
    end
  end

  // R3: a readout only ends after time has moved past the window end
  assert_close_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ({1'b0, $past(now_time)} > t_end));

  // R1: an idle ring that is full stays full when a record arrives
  assert_keep_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && full && rec_valid && !start) |=> (pend == CNT_W'(DEPTH)));

  // R8: a readout never accepts a record into a ring of unexamined entries
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && full && !pop) |=> (pend == CNT_W'(DEPTH)));
endmodule

// File: rtl/pwr_rec_packer.sv
module pwr_rec_packer
  import pwr_pkg::*;
#(
  parameter int TS_W  = 24,
  parameter int AMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TS_W-1:0]  in_ts,
  input  logic [AMP_W-1:0] in_amp,
  output logic             byte_valid,
  input  logic             byte_ready,
  output byte_t            byte_data,
  output logic             holding
);
  localparam int W     = TS_W + AMP_W;
  localparam int NB    = W / 8;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic [W-1:0]     sh;
  logic [IDX_W-1:0] left;

  assign in_ready   = !holding;
  assign byte_valid = holding;
  assign byte_data  = sh[W-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      left    <= '0;
      holding <= 1'b0;
    end else if (in_valid && !holding) begin
      sh      <= {in_ts, in_amp};
      left    <= IDX_W'(NB - 1);
      holding <= 1'b1;
    end else if (holding && byte_ready) begin
      sh <= sh << 8;
      if (left == '0) holding <= 1'b0;
      else            left    <= left - 1'b1;
    end
  end

  // R4: an offered byte holds still until the FIFO takes it
  assert_byte_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));
endmodule

// File: rtl/pwr_byte_fifo.sv
module pwr_byte_fifo
  import pwr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  byte_t in_data,
  output logic  out_valid,
  input  logic  out_ready,
  output byte_t out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  byte_t          mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic           push, pull;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pull      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pull) rp <= nxt(rp);
      unique case ({push, pull})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  // R4: bytes leave in the order they entered; the head holds until taken
  assert_head_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pwr_uart_tx.sv
module pwr_uart_tx
  import pwr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 115_200
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  byte_t in_data,
  output logic  line,
  output logic  sending
);
  localparam logic [32:0] INC = 33'(TICKS_PER_BIT * BAUD);
  localparam logic [32:0] LIM = 33'(CLK_HZ);

  logic [32:0]     acc, acc_sum;
  logic            tick;
  logic [8:0]      frame;
  logic [3:0]      bits_left;
  logic [TICK_W-1:0] phase;

  assign acc_sum  = acc + INC;
  assign tick     = (acc_sum >= LIM);
  assign in_ready = !sending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= tick ? acc_sum - LIM : acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame     <= '1;
      bits_left <= '0;
      phase     <= '0;
      sending   <= 1'b0;
      line      <= 1'b1;
    end else if (!sending) begin
      if (in_valid) begin
        frame     <= {1'b1, in_data};
        bits_left <= 4'(SHIFT_BITS);
        phase     <= '0;
        sending   <= 1'b1;
        line      <= 1'b0;
      end
    end else if (tick) begin
      phase <= phase + 1'b1;
      if (phase == TICK_W'(TICKS_PER_BIT - 1)) begin
        if (bits_left == '0) begin
          sending <= 1'b0;
        end else begin
          line      <= frame[0];
          frame     <= {1'b1, frame[8:1]};
          bits_left <= bits_left - 1'b1;
        end
      end
    end
  end

  // R5: the line only changes on a tick while a frame is in flight
  assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !tick) |=> $stable(line));

  // R6: the fractional remainder stays below one clock-rate unit
  assert_acc_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc < LIM);
endmodule

// File: rtl/peak_window_readout.sv
module peak_window_readout
  import pwr_pkg::*;
#(
  parameter int          DEPTH      = 16,
  parameter int          TS_W       = 24,
  parameter int          AMP_W      = 16,
  parameter int          FIFO_DEPTH = 16,
  parameter int          DROP_W     = 8,
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned BAUD       = 115_200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_valid,
  output logic              pk_ready,
  input  logic [TS_W-1:0]   pk_time,
  input  logic [AMP_W-1:0]  pk_amp,
  input  logic              trigger,
  input  logic [TS_W-1:0]   now_time,
  input  logic [TS_W-1:0]   win_len,
  output logic              uart_tx,
  output logic              busy,
  output logic [DROP_W-1:0] dropped_trig
);
  logic             scan_active, sel_valid, sel_ready;
  logic [TS_W-1:0]  sel_ts;
  logic [AMP_W-1:0] sel_amp;
  logic             pk_holding, b_valid, b_ready, f_valid, f_ready, tx_sending;
  byte_t            b_data, f_data;
  logic             start;

  assign busy  = scan_active || pk_holding || f_valid || tx_sending;
  assign start = trigger && !busy;

  pwr_ring_scan #(.DEPTH(DEPTH), .TS_W(TS_W), .AMP_W(AMP_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .rec_valid(pk_valid), .rec_ready(pk_ready), .rec_ts(pk_time), .rec_amp(pk_amp),
    .start(start), .now_time(now_time), .win_len(win_len), .active(scan_active),
    .out_valid(sel_valid), .out_ready(sel_ready), .out_ts(sel_ts), .out_amp(sel_amp)
  );

  pwr_rec_packer #(.TS_W(TS_W), .AMP_W(AMP_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sel_valid), .in_ready(sel_ready), .in_ts(sel_ts), .in_amp(sel_amp),
    .byte_valid(b_valid), .byte_ready(b_ready), .byte_data(b_data), .holding(pk_holding)
  );

  pwr_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(b_valid), .in_ready(b_ready), .in_data(b_data),
    .out_valid(f_valid), .out_ready(f_ready), .out_data(f_data)
  );

  pwr_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(f_valid), .in_ready(f_ready), .in_data(f_data),
    .line(uart_tx), .sending(tx_sending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   dropped_trig <= '0;
    else if (trigger && busy && (dropped_trig != '1)) dropped_trig <= dropped_trig + 1'b1;
  end

  // R7: with no readout pending the serial line rests high
  assert_quiet_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> uart_tx);

  // R7: a trigger during a readout leaves one more count behind
  assert_drop_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && busy && (dropped_trig != '1)) |=> (dropped_trig == $past(dropped_trig) + 1'b1));

  // R7: busy rises right after an accepted trigger
  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: tb/tb_peak_window_readout.sv
module tb_peak_window_readout;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pk_valid = 0;
  logic        pk_ready;
  logic [23:0] pk_time = '0;
  logic [15:0] pk_amp = '0;
  logic        trigger = 0;
  logic [23:0] now_time = '0;
  logic [23:0] win_len = '0;
  logic        uart_tx, busy;
  logic [7:0]  dropped_trig;

  int checks = 0, fails = 0;
  logic [7:0] got [0:63];
  logic       ready_low_seen = 0;

  always #2 clk = ~clk;

  peak_window_readout #(
    .DEPTH(4), .TS_W(24), .AMP_W(16), .FIFO_DEPTH(4), .DROP_W(8),
    .CLK_HZ(250_000_000), .BAUD(12_500_000)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pk_valid(pk_valid), .pk_ready(pk_ready),
    .pk_time(pk_time), .pk_amp(pk_amp), .trigger(trigger), .now_time(now_time),
    .win_len(win_len), .uart_tx(uart_tx), .busy(busy), .dropped_trig(dropped_trig)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] pkt_byte(input logic [23:0] ts, input logic [15:0] amp, input int k);
    logic [39:0] w = {ts, amp};
    return w[39 - 8*k -: 8];
  endfunction

  task automatic push_rec(input logic [23:0] ts, input logic [15:0] amp);
    @(negedge clk);
    pk_valid = 1; pk_time = ts; pk_amp = amp;
    while (!pk_ready) begin ready_low_seen = 1; @(negedge clk); end
    @(posedge clk); #1 pk_valid = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trigger = 1;
    @(negedge clk); trigger = 0;
  endtask

  task automatic rx_byte(output logic [7:0] b);
    while (uart_tx) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(uart_tx == 0, "R5 start bit low", uart_tx, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (20) @(negedge clk);
      b[i] = uart_tx;
    end
    repeat (20) @(negedge clk);
    chk(uart_tx == 1, "R5 stop bit high", uart_tx, 1);
  endtask

  task automatic rx_n(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      rx_byte(b);
      got[base + i] = b;
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(uart_tx == 1, "R9 tx idle", uart_tx, 1);
    chk(busy == 0, "R9 busy low", busy, 0);
    chk(pk_ready == 1, "R9 ready high", pk_ready, 1);
    chk(dropped_trig == 0, "R9 drop count", dropped_trig, 0);
  endtask

  task automatic t_window();
    push_rec(24'd149, 16'h1111);
    push_rec(24'd150, 16'h2222);
    push_rec(24'd250, 16'h3333);
    push_rec(24'd251, 16'h4444);
    @(negedge clk); now_time = 24'd150; win_len = 24'd100;
    pulse_trig();
    chk(busy == 1, "R7 busy after trigger", busy, 1);
    now_time = 24'd251;
    rx_n(10, 0);
    for (int k = 0; k < 5; k++)
      chk(got[k] == pkt_byte(24'd150, 16'h2222, k), "R2 R4 window start record", got[k], pkt_byte(24'd150, 16'h2222, k));
    for (int k = 0; k < 5; k++)
      chk(got[5+k] == pkt_byte(24'd250, 16'h3333, k), "R2 R4 window end record", got[5+k], pkt_byte(24'd250, 16'h3333, k));
    wait_idle();
    repeat (60) @(negedge clk);
    chk(uart_tx == 1, "R2 no extra bytes", uart_tx, 1);
    chk(busy == 0, "R7 busy cleared", busy, 0);
  endtask

  task automatic t_late();
    int len = 0;
    logic [7:0] b;
    @(negedge clk); now_time = 24'd1000; win_len = 24'd50;
    pulse_trig();
    repeat (5) @(negedge clk);
    chk(busy == 1, "R3 open with empty ring", busy, 1);
    push_rec(24'd1020, 16'hA55A);
    while (uart_tx) @(negedge clk);
    while (!uart_tx) begin len++; @(negedge clk); end
    chk(len >= 179 && len <= 181, "R6 zero byte low run", len, 180);
    for (int k = 1; k < 5; k++) begin
      rx_byte(b);
      chk(b == pkt_byte(24'd1020, 16'hA55A, k), "R3 late record byte", b, pkt_byte(24'd1020, 16'hA55A, k));
    end
    repeat (40) @(negedge clk);
    chk(busy == 1, "R3 still open inside window", busy, 1);
    now_time = 24'd1050;
    repeat (40) @(negedge clk);
    chk(busy == 1, "R3 open at window end", busy, 1);
    now_time = 24'd1051;
    repeat (40) @(negedge clk);
    chk(busy == 0, "R3 closes past window", busy, 0);
  endtask

  task automatic t_drop();
    @(negedge clk); now_time = 24'd3000; win_len = 24'd10;
    pulse_trig();
    pulse_trig();
    pulse_trig();
    @(negedge clk);
    chk(dropped_trig == 2, "R7 ignored triggers counted", dropped_trig, 2);
    now_time = 24'd3011;
    wait_idle();
    chk(busy == 0, "R7 readout ends once", busy, 0);
    chk(uart_tx == 1, "R7 ignored triggers send nothing", uart_tx, 1);
  endtask

  task automatic t_wrap();
    for (int i = 1; i <= 6; i++) push_rec(24'(4000 + i), 16'(16'h5000 + i));
    @(negedge clk);
    chk(pk_ready == 1, "R1 idle never back-pressures", pk_ready, 1);
    now_time = 24'd4000; win_len = 24'd100;
    pulse_trig();
    now_time = 24'd4200;
    rx_n(20, 0);
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 5; k++)
        chk(got[5*r+k] == pkt_byte(24'(4003 + r), 16'(16'h5003 + r), k), "R1 newest records kept",
            got[5*r+k], pkt_byte(24'(4003 + r), 16'(16'h5003 + r), k));
    wait_idle();
  endtask

  task automatic t_backpressure();
    @(negedge clk); now_time = 24'd5000; win_len = 24'd1000;
    pulse_trig();
    ready_low_seen = 0;
    fork
      for (int i = 0; i < 10; i++) push_rec(24'(5001 + i), 16'(16'h6000 + i));
      rx_n(50, 0);
    join
    chk(ready_low_seen == 1, "R8 ready dropped when ring full", ready_low_seen, 1);
    for (int r = 0; r < 10; r++)
      for (int k = 0; k < 5; k++)
        chk(got[5*r+k] == pkt_byte(24'(5001 + r), 16'(16'h6000 + r), k), "R8 no record lost",
            got[5*r+k], pkt_byte(24'(5001 + r), 16'(16'h6000 + r), k));
    now_time = 24'd6001;
    wait_idle();
    chk(busy == 0, "R8 readout ends", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_window();
    t_late();
    t_drop();
    t_wrap();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule